// File: doc/BRIEF.md
# Fetch-Address Branch Target Predictor

This block is a small tagged cache that the fetch stage consults with nothing but the address it is about to fetch. It answers before the instruction word has been decoded. The buffer only ever holds branches that were last seen taken. A hit therefore means "redirect to the stored target", and a miss means "carry on sequentially". When the prediction is right, the pipeline loses no cycles to the branch.

The buffer is direct-mapped. The entry index comes from the address bits just above the instruction offset. The remaining upper bits are stored as a tag beside a valid bit, the branch target and a small saturating confidence counter. The counter is reported with every hit so that a neighbouring direction predictor can weigh the redirect.

After a branch resolves, the back end reports its address, its outcome and its real target:
- A taken branch writes its entry, or overwrites whatever occupies that slot.
- A not-taken branch that finds its own entry removes it.
- A not-taken branch that finds a different entry, or an empty slot, leaves the slot alone.

Each lookup produces its answer on registered outputs one cycle later. A lookup and an update in the same cycle see the contents that were there before that update.

Top module: `btb_top`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `pred_valid` and `pred_hit` are 0. Every entry is invalid after reset, so any lookup made after reset misses until a taken update is made.
- R2: `pred_valid` in a cycle equals `fetch_valid` of the previous cycle. While `pred_valid` is 0, `pred_hit` is 0.
- R3: When a lookup misses, one cycle later `pred_hit` is 0, `pred_conf` is 0 and `pred_next` equals the lookup address plus INSTR_BYTES (default 4).
- R4: After a taken update for address A with target T, a later lookup of A hits and returns `pred_next` = T. This holds until another update touches A's index.
- R5: A taken update overwrites the indexed entry, whether it held a different tag or the same tag with another target. Afterwards the old address misses and the new address hits with the new target.
- R6: A not-taken update whose address matches a valid entry invalidates it, so a later lookup of that address misses. A not-taken update whose tag does not match leaves the entry intact.
- R7: An address with the same index bits (address bits [IDX_W+1:2]) but different upper bits misses.
- R8: When a lookup and an update address the same index in one cycle, the lookup result reflects the contents from before that update.
- R9: `pred_conf` on a hit behaves as a saturating counter:
  - It is 0 right after an entry is allocated or replaced.
  - Each further taken update for the same address increments it.
  - It saturates at 2^CONF_W-1 (3 by default).
  - On a miss it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A lookup is requested this cycle |
| fetch_addr | input | ADDR_W | Address being fetched |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | 1 = branch was taken, 0 = not taken |
| upd_target | input | ADDR_W | Actual target of the resolved branch |
| pred_valid | output | 1 | Result of the previous cycle's lookup is present |
| pred_hit | output | 1 | The lookup found a matching entry |
| pred_next | output | ADDR_W | Predicted next fetch address |
| pred_conf | output | CONF_W | Confidence counter of the hit entry, 0 on a miss |

## Verification
The bench goes after these corner cases:
- **Aliasing.** Two addresses share one index but differ in their upper bits. A design that dropped or shortened the tag compare would redirect the alias to the wrong target.
- **Not-taken update on a foreign entry.** A not-taken report arrives for an address whose slot holds another tag. A design that cleared the valid bit on the index alone would lose a good entry.
- **Same-cycle lookup and update to one slot.** The bench runs this both for eviction and for allocation. A write-first memory, or a bypassed tag compare, would return the new contents one cycle early.
- **Confidence counter edges.** The bench pushes the counter to saturation and also replaces the entry. A counter that wraps, or that keeps its value across a replacement, shows up as a wrong `pred_conf` on the next hit.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // What a resolved-branch report does to the entry it indexes.
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_ALLOC   = 2'd1,
    UPD_REFRESH = 2'd2,
    UPD_EVICT   = 2'd3
  } upd_kind_e;

  function automatic logic writes_target(upd_kind_e k);
    return (k == UPD_ALLOC) || (k == UPD_REFRESH);
  endfunction

endpackage

// File: rtl/btb_tag_store.sv
module btb_tag_store
  import btb_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 24,
  parameter int CONF_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              up_valid,
  input  logic              up_taken,
  input  logic [IDX_W-1:0]  up_idx,
  input  logic [TAG_W-1:0]  up_tag,
  output upd_kind_e         up_kind,
  output logic              hit_q,
  output logic [CONF_W-1:0] conf_q
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  logic [DEPTH-1:0]  valid_r;
  logic [TAG_W-1:0]  tag_r  [DEPTH];
  logic [CONF_W-1:0] conf_r [DEPTH];

  logic up_match;
  logic lk_match;

  // Decide what the update does, using the contents before this edge.
  always_comb begin
    up_match = valid_r[up_idx] && (tag_r[up_idx] == up_tag);
    if (!up_valid) begin
      up_kind = UPD_NONE;
    end else if (up_taken) begin
      up_kind = up_match ? UPD_REFRESH : UPD_ALLOC;
    end else begin
      up_kind = up_match ? UPD_EVICT : UPD_NONE;
    end
  end

  // Valid bits are the only state that needs a reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r <= '0;
    end else begin
      case (up_kind)
        UPD_ALLOC, UPD_REFRESH: valid_r[up_idx] <= 1'b1;
        UPD_EVICT:              valid_r[up_idx] <= 1'b0;
        default: ;
      endcase
    end
  end

  // Tag and confidence storage, written without reset.
  always_ff @(posedge clk) begin
    case (up_kind)
      UPD_ALLOC: begin
        tag_r[up_idx]  <= up_tag;
        conf_r[up_idx] <= '0;
      end
      UPD_REFRESH: begin
        if (conf_r[up_idx] != CONF_MAX) begin
          conf_r[up_idx] <= conf_r[up_idx] + 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Lookup compare happens in the fetch cycle; the result is registered.
  assign lk_match = valid_r[lk_idx] && (tag_r[lk_idx] == lk_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      conf_q <= '0;
    end else begin
      hit_q  <= lk_valid && lk_match;
      conf_q <= (lk_valid && lk_match) ? conf_r[lk_idx] : '0;
    end
  end

endmodule

// File: rtl/btb_target_ram.sv
module btb_target_ram #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port, read-first: a read of the address being written
  // returns the word stored before this edge.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata_q <= mem[raddr];
    end
  end

endmodule

// File: rtl/btb_next_sel.sv
module btb_next_sel #(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              hit_q,
  input  logic [ADDR_W-1:0] tgt_q,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_next
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic              valid_q;
  logic [ADDR_W-1:0] seq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      seq_q   <= '0;
    end else begin
      valid_q <= lk_valid;
      seq_q   <= lk_addr + STEP;
    end
  end

  assign pred_valid = valid_q;
  assign pred_next  = hit_q ? tgt_q : seq_q;

endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 6,
  parameter int INSTR_BYTES = 4,
  parameter int CONF_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_next,
  output logic [CONF_W-1:0] pred_conf
);

  localparam int OFS_W = $clog2(INSTR_BYTES);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  upd_kind_e         up_kind;
  logic              hit_q;
  logic [CONF_W-1:0] conf_q;
  logic [ADDR_W-1:0] tgt_q;

  assign lk_idx = fetch_addr[OFS_W +: IDX_W];
  assign lk_tag = fetch_addr[ADDR_W-1 -: TAG_W];
  assign up_idx = upd_pc[OFS_W +: IDX_W];
  assign up_tag = upd_pc[ADDR_W-1 -: TAG_W];

  btb_tag_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .CONF_W(CONF_W)
  ) u_tags (
    .clk     (clk),
    .rst     (rst),
    .lk_valid(fetch_valid),
    .lk_idx  (lk_idx),
    .lk_tag  (lk_tag),
    .up_valid(upd_valid),
    .up_taken(upd_taken),
    .up_idx  (up_idx),
    .up_tag  (up_tag),
    .up_kind (up_kind),
    .hit_q   (hit_q),
    .conf_q  (conf_q)
  );

  btb_target_ram #(
    .IDX_W (IDX_W),
    .DATA_W(ADDR_W)
  ) u_tgt (
    .clk    (clk),
    .we     (writes_target(up_kind)),
    .waddr  (up_idx),
    .wdata  (upd_target),
    .re     (fetch_valid),
    .raddr  (lk_idx),
    .rdata_q(tgt_q)
  );

  btb_next_sel #(
    .ADDR_W     (ADDR_W),
    .INSTR_BYTES(INSTR_BYTES)
  ) u_next (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (fetch_valid),
    .lk_addr   (fetch_addr),
    .hit_q     (hit_q),
    .tgt_q     (tgt_q),
    .pred_valid(pred_valid),
    .pred_next (pred_next)
  );

  assign pred_hit  = hit_q;
  assign pred_conf = conf_q;

endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 6,
  parameter int INSTR_BYTES = 4,
  parameter int CONF_W      = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_pc,
  input logic              upd_taken,
  input logic [ADDR_W-1:0] upd_target,
  input logic              pred_valid,
  input logic              pred_hit,
  input logic [ADDR_W-1:0] pred_next,
  input logic [CONF_W-1:0] pred_conf
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!pred_valid && !pred_hit));

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid);

  // R2
  idle_no_result_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> (!pred_valid && !pred_hit));

  // R3
  miss_sequential_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (pred_hit || (pred_next == $past(fetch_addr) + STEP)));

  // R9
  miss_conf_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (pred_conf == '0));

  // R4
  alloc_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_valid && upd_taken) && fetch_valid && (fetch_addr == $past(upd_pc)))
      |=> (pred_hit && (pred_next == $past(upd_target, 2))));

  // R6
  evict_then_miss_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_valid && !upd_taken) && fetch_valid && (fetch_addr == $past(upd_pc)))
      |=> !pred_hit);

endmodule

bind btb_top btb_chk #(
  .ADDR_W     (ADDR_W),
  .IDX_W      (IDX_W),
  .INSTR_BYTES(INSTR_BYTES),
  .CONF_W     (CONF_W)
) u_chk (.*);

// File: tb/sim_btb_top.sv
`timescale 1ns/1ps
module sim_btb_top;

  localparam int ADDR_W = 32;
  localparam int IDX_W  = 6;
  localparam int CONF_W = 2;
  localparam int OFS_W  = 2;
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fetch_valid = 1'b0;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic              upd_valid = 1'b0;
  logic [ADDR_W-1:0] upd_pc = '0;
  logic              upd_taken = 1'b0;
  logic [ADDR_W-1:0] upd_target = '0;
  logic              pred_valid, pred_hit;
  logic [ADDR_W-1:0] pred_next;
  logic [CONF_W-1:0] pred_conf;

  always #2.5 clk = ~clk;

  btb_top #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .INSTR_BYTES(4), .CONF_W(CONF_W)) u0 (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .pred_valid(pred_valid), .pred_hit(pred_hit),
    .pred_next(pred_next), .pred_conf(pred_conf)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string lbl = "R1";

  // Bench model of the buffer contents.
  bit                m_valid [DEPTH];
  logic [TAG_W-1:0]  m_tag   [DEPTH];
  logic [ADDR_W-1:0] m_tgt   [DEPTH];
  logic [CONF_W-1:0] m_conf  [DEPTH];

  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(logic [TAG_W-1:0] t, logic [IDX_W-1:0] i);
    return {t, i, 2'b00};
  endfunction

  function automatic bit model_match(logic [ADDR_W-1:0] a);
    return m_valid[idx_of(a)] && (m_tag[idx_of(a)] == tag_of(a));
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, compare at the next falling edge.
  task automatic cyc(bit fv, logic [ADDR_W-1:0] fa, bit uv,
                     logic [ADDR_W-1:0] upc, bit ut, logic [ADDR_W-1:0] utgt);
    bit                e_hit;
    logic [ADDR_W-1:0] e_next;
    logic [CONF_W-1:0] e_conf;
    logic [IDX_W-1:0]  ui;
    fetch_valid = fv; fetch_addr = fa;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utgt;
    e_hit  = fv && model_match(fa);
    e_next = e_hit ? m_tgt[idx_of(fa)] : fa + 32'd4;
    e_conf = e_hit ? m_conf[idx_of(fa)] : '0;
    if (uv) begin
      ui = idx_of(upc);
      if (ut) begin
        if (model_match(upc)) begin
          if (m_conf[ui] != '1) m_conf[ui] = m_conf[ui] + 1'b1;
        end else begin
          m_conf[ui] = '0;
        end
        m_valid[ui] = 1'b1; m_tag[ui] = tag_of(upc); m_tgt[ui] = utgt;
      end else if (model_match(upc)) begin
        m_valid[ui] = 1'b0;
      end
    end
    @(negedge clk);
    if (fv) begin
      check(lbl, {29'd0, pred_valid, pred_hit, pred_conf, pred_next},
                 {29'd0, 1'b1, e_hit, e_conf, e_next});
    end else begin
      check(lbl, {62'd0, pred_valid, pred_hit}, 64'd0);
    end
  endtask

  task automatic look(logic [ADDR_W-1:0] a);
    cyc(1'b1, a, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic upd(logic [ADDR_W-1:0] pc, bit taken, logic [ADDR_W-1:0] tgt);
    cyc(1'b0, '0, 1'b1, pc, taken, tgt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_conf[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1", {62'd0, pred_valid, pred_hit}, 64'd0);
    rst = 1'b0;
    lbl = "R1";
    cyc(1'b0, '0, 1'b0, '0, 1'b0, '0);
    look(32'h0000_0100);
    look(32'h0000_1000);
    lbl = "R2";
    cyc(1'b0, 32'h0000_1000, 1'b0, '0, 1'b0, '0);
    lbl = "R3";
    look(32'hFFFF_FFFC);
    look(32'h0000_0040);
    lbl = "R4";
    upd(32'h0000_1000, 1'b1, 32'h0000_2000);
    look(32'h0000_1000);
    lbl = "R9";
    upd(32'h0000_1000, 1'b1, 32'h0000_2000);
    upd(32'h0000_1000, 1'b1, 32'h0000_2000);
    look(32'h0000_1000);
    upd(32'h0000_1000, 1'b1, 32'h0000_2000);
    upd(32'h0000_1000, 1'b1, 32'h0000_2000);
    look(32'h0000_1000);
    lbl = "R7";
    look(32'h0000_1100);
    look(32'h8000_1000);
    lbl = "R5";
    upd(32'h0000_1100, 1'b1, 32'h0000_3000);
    look(32'h0000_1100);
    look(32'h0000_1000);
    upd(32'h0000_1100, 1'b1, 32'h0000_3400);
    look(32'h0000_1100);
    lbl = "R6";
    upd(32'h0000_1000, 1'b0, '0);
    look(32'h0000_1100);
    upd(32'h0000_1100, 1'b0, '0);
    look(32'h0000_1100);
    lbl = "R8";
    upd(32'h0000_2040, 1'b1, 32'h0000_5000);
    cyc(1'b1, 32'h0000_2040, 1'b1, 32'h0000_2040, 1'b0, '0);
    look(32'h0000_2040);
    cyc(1'b1, 32'h0000_2080, 1'b1, 32'h0000_2080, 1'b1, 32'h0000_6000);
    look(32'h0000_2080);
    cyc(1'b1, 32'h0000_2080, 1'b1, 32'h0000_2080, 1'b1, 32'h0000_7000);
    look(32'h0000_2080);
    // Random mix over a small address pool so hits, aliases and evictions recur.
    for (int n = 0; n < 3000; n++) begin
      logic [ADDR_W-1:0] fa, pc, tg;
      bit fv, uv, ut;
      fv = ($urandom % 4) != 0;
      uv = ($urandom % 2) != 0;
      ut = ($urandom % 3) != 0;
      fa = mk_addr(TAG_W'($urandom % 4), IDX_W'($urandom % 8));
      pc = ($urandom % 3 == 0) ? fa : mk_addr(TAG_W'($urandom % 4), IDX_W'($urandom % 8));
      tg = {$urandom, 2'b00} >> 2 << 2;
      if (!fv) lbl = "R2";
      else if (model_match(fa)) lbl = "R4";
      else lbl = "R3";
      cyc(fv, fa, uv, pc, ut, tg);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule